// File: doc/BRIEF.md
# Indirect Clause-45 Register Window

This block gives a host reach into a 16-bit register space organised as device number plus register number, of the kind used by Clause-45 management. The host sees only two 32-bit locations: a pointer that holds the combined device and register number, and a data window. The host loads the pointer first. It then reads or writes the window, and the block turns that window access into exactly one request on an internal request/acknowledge port.

The host bus is a plain synchronous register bus. It has a read strobe, a write strobe, a location select and a port number. The host holds a strobe until the block raises `host_ready`. A window access stalls the bus until the internal side acknowledges. Only port number 0 is served. Any other port number is refused at once with `host_err` and never reaches the internal side.

Top module: `c45_window`

## Requirements
- R1: With `host_sel`=0 (pointer location) and port 0, a write stores the device number from `host_wdata[20:16]` and the register number from `host_wdata[15:0]`. The access completes in the same cycle (`host_ready`=1). A pointer read returns the stored value in bits [20:0], with bits [31:21] zero.
- R2: With `host_sel`=1 (window location) and port 0, a read issues one internal read with `int_we`=0 and `int_addr` = {device[20:16], register[15:0]} taken from the pointer. It returns the acknowledged 16-bit `int_rdata` in `host_rdata[15:0]`, with bits [31:16] zero.
- R3: A window write issues one internal write with `int_we`=1, `int_wdata` = `host_wdata[15:0]` and the pointer as `int_addr`.
- R4: The pointer keeps its value across window accesses, so consecutive window accesses reach the same internal register until the pointer is rewritten.
- R5: An access with a nonzero `host_port` completes in the same cycle with `host_err`=1 and `host_rdata`=0. It issues no internal request and leaves the pointer unchanged.
- R6: During a window access `host_ready` stays low until `int_ack` is sampled high. The host sees `host_ready` in the cycle after that edge.
- R7: Pointer reads and writes start no internal request.
- R8: Once raised, `int_req` stays high with `int_addr`, `int_we` and `int_wdata` stable until `int_ack` is sampled.
- R9: Reset clears the pointer to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_rd | input | 1 | Host read strobe, held until ready |
| host_wr | input | 1 | Host write strobe, held until ready |
| host_sel | input | 1 | 0 selects the pointer, 1 selects the data window |
| host_port | input | 5 | Port number of the access; only 0 is served |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, valid while ready is high |
| host_ready | output | 1 | Access completes this cycle |
| host_err | output | 1 | Access refused (nonzero port) |
| int_req | output | 1 | Internal request |
| int_we | output | 1 | Internal request is a write |
| int_addr | output | 21 | Internal address {device, register} |
| int_wdata | output | 16 | Internal write data |
| int_ack | input | 1 | Internal acknowledge |
| int_rdata | input | 16 | Internal read data, valid with ack |

## Verification
Window reads are run against a modelled register space where every unwritten location returns a value derived from its own address. A read through a wrong pointer field therefore gives a visibly different result. Write-then-read sequences that use several device numbers and register numbers separate the device field from the register field. Repeated window accesses without a new pointer write show that the pointer is retained. Accesses on nonzero ports, and accesses to the pointer itself, are followed by a check of the count of forwarded requests. The acknowledge delay is swept so that the measured stall length shows that completion follows the acknowledge rather than a fixed delay.

// File: rtl/c45_window.sv
module c45_window #(
  parameter int HOST_W = 32,
  parameter int DEV_W  = 5,
  parameter int REG_W  = 16,
  parameter int DATA_W = 16,
  parameter int PORT_W = 5,
  localparam int ADDR_W = DEV_W + REG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic              host_sel,
  input  logic [PORT_W-1:0] host_port,
  input  logic [HOST_W-1:0] host_wdata,
  output logic [HOST_W-1:0] host_rdata,
  output logic              host_ready,
  output logic              host_err,
  output logic              int_req,
  output logic              int_we,
  output logic [ADDR_W-1:0] int_addr,
  output logic [DATA_W-1:0] int_wdata,
  input  logic              int_ack,
  input  logic [DATA_W-1:0] int_rdata
);

  typedef enum logic [1:0] {S_IDLE, S_BUSY, S_DONE} state_t;

  state_t            state;
  logic [ADDR_W-1:0] ptr_q;
  logic [DATA_W-1:0] rd_q;
  logic [DATA_W-1:0] wd_q;
  logic              we_q;

  logic idle, access, bad_port, reject, ptr_acc, win_start;

  assign idle      = (state == S_IDLE);
  assign access    = host_rd | host_wr;
  assign bad_port  = |host_port;
  assign reject    = idle & access & bad_port;
  assign ptr_acc   = idle & access & ~bad_port & ~host_sel;
  assign win_start = idle & access & ~bad_port & host_sel;

  assign host_ready = reject | ptr_acc | (state == S_DONE);
  assign host_err   = reject;

  always_comb begin
    host_rdata = '0;
    if (ptr_acc)
      host_rdata = {{(HOST_W-ADDR_W){1'b0}}, ptr_q};
    else if (state == S_DONE)
      host_rdata = {{(HOST_W-DATA_W){1'b0}}, rd_q};
  end

  assign int_req   = (state == S_BUSY);
  assign int_we    = we_q;
  assign int_addr  = ptr_q;
  assign int_wdata = wd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      ptr_q <= '0;
      rd_q  <= '0;
      wd_q  <= '0;
      we_q  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (ptr_acc && host_wr)
            ptr_q <= host_wdata[ADDR_W-1:0];
          if (win_start) begin
            we_q  <= host_wr;
            wd_q  <= host_wdata[DATA_W-1:0];
            state <= S_BUSY;
          end
        end
        S_BUSY: begin
          if (int_ack) begin
            if (!we_q) rd_q <= int_rdata;
            state <= S_DONE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/c45_window_chk.sv
module c45_window_chk #(
  parameter int HOST_W = 32,
  parameter int DATA_W = 16,
  parameter int PORT_W = 5,
  parameter int ADDR_W = 21
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_rd,
  input logic              host_wr,
  input logic              host_sel,
  input logic [PORT_W-1:0] host_port,
  input logic [HOST_W-1:0] host_rdata,
  input logic              host_ready,
  input logic              host_err,
  input logic              int_req,
  input logic              int_we,
  input logic [ADDR_W-1:0] int_addr,
  input logic [DATA_W-1:0] int_wdata,
  input logic              int_ack
);

  p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_ready && host_rd && host_sel && !host_err) |-> (host_rdata[HOST_W-1:DATA_W] == '0));

  p_reject_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    host_err |-> (host_ready && host_rdata == '0));

  p_reject_noreq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((host_rd || host_wr) && host_port != '0 && !int_req) |=> !int_req);

  p_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> !host_ready);

  p_ptr_noreq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!int_req && !host_sel) |=> !int_req);

  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (int_req && !int_ack) |=> (int_req && $stable(int_addr) && $stable(int_we) && $stable(int_wdata)));

endmodule

bind c45_window c45_window_chk #(
  .HOST_W(HOST_W), .DATA_W(DATA_W), .PORT_W(PORT_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .host_wr(host_wr),
  .host_sel(host_sel), .host_port(host_port), .host_rdata(host_rdata),
  .host_ready(host_ready), .host_err(host_err), .int_req(int_req),
  .int_we(int_we), .int_addr(int_addr), .int_wdata(int_wdata), .int_ack(int_ack)
);

// File: tb/c45_window_tb_top.sv
module c45_window_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_rd = 1'b0, host_wr = 1'b0, host_sel = 1'b0;
  logic [4:0]  host_port = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        host_ready, host_err;
  logic        int_req, int_we, int_ack = 1'b0;
  logic [20:0] int_addr;
  logic [15:0] int_wdata, int_rdata = '0;

  int checks = 0, errors = 0;
  int lat = 0, lat_cnt = 0, fwd_cnt = 0;
  logic [15:0] regs [logic [20:0]];

  always #5 clk = ~clk;

  c45_window dut_i (
    .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .host_wr(host_wr),
    .host_sel(host_sel), .host_port(host_port), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_ready(host_ready), .host_err(host_err),
    .int_req(int_req), .int_we(int_we), .int_addr(int_addr),
    .int_wdata(int_wdata), .int_ack(int_ack), .int_rdata(int_rdata)
  );

  function automatic logic [15:0] dflt(logic [20:0] a);
    return a[15:0] ^ {a[20:16], 11'h0} ^ 16'hA5C3;
  endfunction

  function automatic logic [15:0] peek(logic [20:0] a);
    return regs.exists(a) ? regs[a] : dflt(a);
  endfunction

  always @(posedge clk) begin
    if (int_req && !int_ack) begin
      if (lat_cnt == lat) begin
        int_ack <= 1'b1;
        lat_cnt <= 0;
        fwd_cnt <= fwd_cnt + 1;
        if (int_we) regs[int_addr] = int_wdata;
        else int_rdata <= peek(int_addr);
      end else lat_cnt <= lat_cnt + 1;
    end else int_ack <= 1'b0;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input logic sel, input logic [4:0] port, input logic wr,
                        input logic [31:0] wd, output logic [31:0] rd,
                        output logic err, output int waits);
    host_sel = sel; host_port = port; host_wdata = wd;
    host_wr = wr; host_rd = !wr;
    waits = 0;
    #1;
    while (!host_ready) begin
      @(negedge clk); #1;
      waits++;
    end
    rd = host_rdata; err = host_err;
    @(posedge clk);
    @(negedge clk);
    host_rd = 1'b0; host_wr = 1'b0; host_port = '0;
  endtask

  task automatic t_reset;
    logic [31:0] r; logic e; int w;
    chk("R9 int_req after reset", {31'b0, int_req}, 32'd0);
    access(1'b0, 5'd0, 1'b0, 32'h0, r, e, w);
    chk("R9 pointer after reset", r, 32'h0);
  endtask

  task automatic t_ptr_rw;
    logic [31:0] r; logic e; int w; int f0;
    f0 = fwd_cnt;
    access(1'b0, 5'd0, 1'b1, 32'hFFF3_1234, r, e, w);
    chk("R1 pointer write ready same cycle", w, 0);
    access(1'b0, 5'd0, 1'b0, 32'h0, r, e, w);
    chk("R1 pointer readback masks upper bits", r, 32'h0013_1234);
    chk("R7 pointer accesses not forwarded", fwd_cnt, f0);
  endtask

  task automatic t_read_pattern(logic [4:0] dev, logic [15:0] rg);
    logic [31:0] r; logic e; int w;
    access(1'b0, 5'd0, 1'b1, {11'h0, dev, rg}, r, e, w);
    access(1'b1, 5'd0, 1'b0, 32'h0, r, e, w);
    chk("R2 window read data", r, {16'h0, peek({dev, rg})});
    chk("R2 window read no error", {31'b0, e}, 32'd0);
  endtask

  task automatic t_write_read(logic [4:0] dev, logic [15:0] rg, logic [15:0] v);
    logic [31:0] r; logic e; int w;
    access(1'b0, 5'd0, 1'b1, {11'h0, dev, rg}, r, e, w);
    access(1'b1, 5'd0, 1'b1, {16'hDEAD, v}, r, e, w);
    chk("R3 stored in modelled register", {16'h0, peek({dev, rg})}, {16'h0, v});
    access(1'b1, 5'd0, 1'b0, 32'h0, r, e, w);
    chk("R3 write then read back", r, {16'h0, v});
  endtask

  task automatic t_retain;
    logic [31:0] r; logic e; int w; int f0;
    access(1'b0, 5'd0, 1'b1, 32'h0007_0042, r, e, w);
    f0 = fwd_cnt;
    access(1'b1, 5'd0, 1'b1, 32'h0000_1111, r, e, w);
    access(1'b1, 5'd0, 1'b1, 32'h0000_2222, r, e, w);
    access(1'b1, 5'd0, 1'b0, 32'h0, r, e, w);
    chk("R4 same register reached", r, 32'h0000_2222);
    chk("R4 neighbour untouched", {16'h0, peek(21'h07_0043)}, {16'h0, dflt(21'h07_0043)});
    chk("R4 three accesses forwarded", fwd_cnt - f0, 3);
    access(1'b0, 5'd0, 1'b0, 32'h0, r, e, w);
    chk("R4 pointer retained", r, 32'h0007_0042);
  endtask

  task automatic t_reject;
    logic [31:0] r; logic e; int w; int f0;
    access(1'b0, 5'd0, 1'b1, 32'h0002_0010, r, e, w);
    f0 = fwd_cnt;
    access(1'b1, 5'd3, 1'b0, 32'h0, r, e, w);
    chk("R5 read on bad port error", {31'b0, e}, 32'd1);
    chk("R5 read on bad port data zero", r, 32'h0);
    chk("R5 read on bad port immediate", w, 0);
    access(1'b1, 5'd1, 1'b1, 32'h0000_BEEF, r, e, w);
    chk("R5 write on bad port error", {31'b0, e}, 32'd1);
    access(1'b0, 5'd16, 1'b1, 32'h0009_9999, r, e, w);
    chk("R5 pointer write on bad port error", {31'b0, e}, 32'd1);
    chk("R5 nothing forwarded", fwd_cnt, f0);
    access(1'b0, 5'd0, 1'b0, 32'h0, r, e, w);
    chk("R5 pointer unchanged", r, 32'h0002_0010);
    access(1'b1, 5'd0, 1'b0, 32'h0, r, e, w);
    chk("R5 register not written", r, {16'h0, dflt(21'h02_0010)});
  endtask

  task automatic t_latency;
    logic [31:0] r; logic e; int w;
    for (int l = 0; l < 5; l++) begin
      lat = l;
      access(1'b1, 5'd0, 1'b0, 32'h0, r, e, w);
      chk("R6 stall follows acknowledge", w, l + 3);
    end
    lat = 0;
  endtask

  initial begin
    #100_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ptr_rw();
    t_read_pattern(5'd1, 16'h0000);
    t_read_pattern(5'd31, 16'hFFFF);
    t_read_pattern(5'd4, 16'h8001);
    t_write_read(5'd3, 16'h0100, 16'h5A5A);
    t_write_read(5'd30, 16'h0100, 16'hFFFF);
    t_retain();
    t_reject();
    t_latency();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule